// File: doc/BRIEF.md
# PCI Interrupt Autodetect Router

This block takes the four legacy interrupt pins (INTA to INTD) of every slot on a PCI bus and folds them onto four level-sensitive host interrupt outputs. How the pins are rotated onto the outputs depends on the board wiring and on a run-time mode. The mode lets an older guest whose interrupt routing assumptions are wrong keep working. It also lets a correct guest keep the proper board rotation.

The mode comes from a small three-state detector. The detector watches configuration writes on their way to the bus. When it sees the first write to a function's interrupt-line register, it decides from the slot and the value written whether the guest expects the legacy identity mapping or the real board rotation. The decision is one-shot. After the detector commits, the mode holds until reset. The guest can then program interrupt-line registers freely. The block only observes the writes and stores none of them. An alternate board variant turns detection off and uses its own rotation.

Top module: `irq_autoroute`

## Requirements
- R1: On a synchronous reset the mode loads `mode_default` (encoding 0 = assume-ok, 1 = broken, 2 = force-ok). The unused code 3 loads assume-ok. All interrupt outputs read 0 after reset.
- R2: Once the mode is broken or force-ok, it does not change again until the next reset, whatever writes arrive.
- R3: A configuration write is examined only when `cfg_addr[7:0]` equals 0x3C. A write to any other offset leaves the mode unchanged.
- R4: While `alt_board` is 1, no write changes the mode.
- R5: A qualifying write in assume-ok mode is classified using s = (`cfg_addr[15:11]` mod 4) and the value v = `cfg_wdata`. If v = 27 and s = 2, the mode stays assume-ok. If v = 27 and s is not 2, the mode becomes broken. If v = s + 27 or v = s + 91, the mode becomes broken. Any other value makes the mode force-ok. The mode changes on the clock edge that samples the write.
- R6: In broken mode, pin p of any slot (p = 0 for INTA up to 3 for INTD, request bit `pin_req[4*slot + p]`) drives output p.
- R7: In assume-ok or force-ok mode, pin p of slot n drives output (n + p + 2) mod 4 when `alt_board` is 0, and output (n + p + 3) mod 4 when `alt_board` is 1.
- R8: Each output is registered. It equals the OR of all requests routed to it on the previous clock edge, so it stays high while any source routed to it holds its request.
- R9: A write presented in a reset cycle is ignored, and the mode after reset is the loaded default.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe, one cycle per write |
| cfg_addr | input | ADDR_W (16) | Configuration address: [7:0] register offset, [15:8] device/function |
| cfg_wdata | input | 8 | Byte written to the register |
| alt_board | input | 1 | 0 = primary board wiring, 1 = alternate board wiring |
| mode_default | input | 2 | Mode loaded at reset |
| pin_req | input | 4*NUM_SLOTS (32) | Level requests, bit 4*slot + pin |
| irq_out | output | 4 | Registered host interrupt levels |
| mode | output | 2 | Current routing mode |

## Verification
The assertions assume that every input is at a known value at each sampled edge and that `rst` is high on the first edge. They also assume that `mode_default` is stable during the cycles when reset is released, because the reset-load property compares the mode with the default sampled one edge earlier. The stimulus keeps within these bounds by starting in reset, changing inputs only at the falling edge, and holding `mode_default` for the whole reset pulse. Random writes are weighted toward offset 0x3C and toward the values 27 to 30 and 91 to 94, so that all three classification outcomes occur. Resets with random defaults, including code 3, appear often enough to re-arm the detector many times.

// File: rtl/irq_autoroute_pkg.sv
package irq_autoroute_pkg;

  typedef enum logic [1:0] {
    MODE_ASSUME = 2'd0,
    MODE_BROKEN = 2'd1,
    MODE_FORCE  = 2'd2
  } route_mode_e;

  localparam int unsigned PINS_PER_SLOT = 4;
  localparam int unsigned HOST_LINES    = 4;
  localparam int unsigned OFF_W         = 8;
  localparam int unsigned SLOT_LSB      = 11;

  localparam logic [OFF_W-1:0] LINE_REG_OFF = 8'h3C;
  localparam logic [7:0]       LEGACY_BASE  = 8'd27;
  localparam logic [7:0]       SHIFTED_BASE = 8'd91;

  // Decide what a guest's first interrupt-line write says about it.
  function automatic route_mode_e classify(input logic [1:0] slot_mod, input logic [7:0] val);
    logic [7:0] s_ext;
    s_ext = {6'd0, slot_mod};
    if (val == LEGACY_BASE) begin
      return (slot_mod == 2'd2) ? MODE_ASSUME : MODE_BROKEN;
    end
    if (val == LEGACY_BASE + s_ext) return MODE_BROKEN;
    if (val == SHIFTED_BASE + s_ext) return MODE_BROKEN;
    return MODE_FORCE;
  endfunction

  // The spare encoding falls back to the undecided state.
  function automatic route_mode_e legal_mode(input logic [1:0] code);
    return (code == 2'd3) ? MODE_ASSUME : route_mode_e'(code);
  endfunction

endpackage

// File: rtl/irq_line_detect.sv
module irq_line_detect
  import irq_autoroute_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic              alt_board,
  input  logic [1:0]        mode_default,
  output route_mode_e       mode_q
);

  localparam int unsigned SLOT_MOD_HI = SLOT_LSB + 1;

  logic        line_hit;
  logic [1:0]  slot_mod;
  route_mode_e verdict;
  logic        unused_addr_bits;

  assign slot_mod  = cfg_addr[SLOT_MOD_HI:SLOT_LSB];
  assign line_hit  = cfg_wr && !alt_board && (cfg_addr[OFF_W-1:0] == LINE_REG_OFF);
  assign verdict   = classify(slot_mod, cfg_wdata);
  assign unused_addr_bits = ^{cfg_addr[SLOT_LSB-1:OFF_W], cfg_addr[ADDR_W-1:SLOT_MOD_HI+1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= legal_mode(mode_default);
    end else if (line_hit && (mode_q == MODE_ASSUME)) begin
      mode_q <= verdict;
    end
  end

endmodule

// File: rtl/irq_pin_router.sv
module irq_pin_router
  import irq_autoroute_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              alt_board,
  input  route_mode_e                       mode_q,
  input  logic [NUM_SLOTS*PINS_PER_SLOT-1:0] pin_req,
  output logic [HOST_LINES-1:0]             irq_out
);

  localparam int unsigned NUM_SRC = NUM_SLOTS * PINS_PER_SLOT;

  logic [HOST_LINES-1:0] src_hit [NUM_SRC];
  logic [HOST_LINES-1:0] irq_d;
  logic                  legacy;

  assign legacy = (mode_q == MODE_BROKEN);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    localparam int unsigned SLOT_N = g / PINS_PER_SLOT;
    localparam int unsigned PIN_N  = g % PINS_PER_SLOT;
    localparam logic [1:0]  ID_DST  = 2'(PIN_N);
    localparam logic [1:0]  PRI_DST = 2'((SLOT_N + PIN_N + 2) % HOST_LINES);
    localparam logic [1:0]  ALT_DST = 2'((SLOT_N + PIN_N + 3) % HOST_LINES);
    logic [1:0] dst;
    always_comb begin
      if (legacy)         dst = ID_DST;
      else if (alt_board) dst = ALT_DST;
      else                dst = PRI_DST;
    end
    assign src_hit[g] = pin_req[g] ? (HOST_LINES'(1) << dst) : '0;
  end

  always_comb begin
    irq_d = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      irq_d = irq_d | src_hit[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_out <= '0;
    else     irq_out <= irq_d;
  end

endmodule

// File: rtl/irq_autoroute.sv
module irq_autoroute
  import irq_autoroute_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned ADDR_W    = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_wr,
  input  logic [ADDR_W-1:0]         cfg_addr,
  input  logic [7:0]                cfg_wdata,
  input  logic                      alt_board,
  input  logic [1:0]                mode_default,
  input  logic [4*NUM_SLOTS-1:0]    pin_req,
  output logic [3:0]                irq_out,
  output logic [1:0]                mode
);

  route_mode_e mode_q;

  irq_line_detect #(.ADDR_W(ADDR_W)) u_detect (
    .clk          (clk),
    .rst          (rst),
    .cfg_wr       (cfg_wr),
    .cfg_addr     (cfg_addr),
    .cfg_wdata    (cfg_wdata),
    .alt_board    (alt_board),
    .mode_default (mode_default),
    .mode_q       (mode_q)
  );

  irq_pin_router #(.NUM_SLOTS(NUM_SLOTS)) u_router (
    .clk       (clk),
    .rst       (rst),
    .alt_board (alt_board),
    .mode_q    (mode_q),
    .pin_req   (pin_req),
    .irq_out   (irq_out)
  );

  assign mode = mode_q;

endmodule

// File: rtl/irq_autoroute_chk.sv
module irq_autoroute_chk #(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned ADDR_W    = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   cfg_wr,
  input logic [ADDR_W-1:0]      cfg_addr,
  input logic                   alt_board,
  input logic [1:0]             mode_default,
  input logic [4*NUM_SLOTS-1:0] pin_req,
  input logic [3:0]             irq_out,
  input logic [1:0]             mode
);

  function automatic logic [3:0] fold_pins(input logic [4*NUM_SLOTS-1:0] req);
    logic [3:0] r;
    r = '0;
    for (int s = 0; s < NUM_SLOTS; s++) r = r | req[4*s +: 4];
    return r;
  endfunction

  function automatic logic [1:0] load_val(input logic [1:0] d);
    return (d == 2'd3) ? 2'd0 : d;
  endfunction

  AST_RESET_LOAD: assert property (@(posedge clk)
    rst |=> (mode == load_val($past(mode_default))) && (irq_out == 4'd0)); // R1

  AST_STICKY_MODE: assert property (@(posedge clk) disable iff (rst)
    (mode != 2'd0) |=> $stable(mode)); // R2

  AST_OTHER_OFFSET: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_addr[7:0] != 8'h3C) |=> $stable(mode)); // R3

  AST_ALT_NO_DETECT: assert property (@(posedge clk) disable iff (rst)
    alt_board |=> $stable(mode)); // R4

  AST_LEGAL_MODE: assert property (@(posedge clk) disable iff (rst)
    mode != 2'd3); // R5

  AST_LEGACY_ROUTE: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd1) |=> (irq_out == $past(fold_pins(pin_req)))); // R6

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    (pin_req == '0) |=> (irq_out == 4'd0)); // R8

  AST_OUT_COUNT: assert property (@(posedge clk) disable iff (rst)
    $countones(irq_out) <= $countones($past(pin_req))); // R8

endmodule

bind irq_autoroute irq_autoroute_chk #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_wr       (cfg_wr),
  .cfg_addr     (cfg_addr),
  .alt_board    (alt_board),
  .mode_default (mode_default),
  .pin_req      (pin_req),
  .irq_out      (irq_out),
  .mode         (mode)
);

// File: tb/irq_autoroute_bench.sv
module irq_autoroute_bench;

  localparam int NSLOT = 8;
  localparam int AW    = 16;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            cfg_wr = 1'b0;
  logic [AW-1:0]   cfg_addr = '0;
  logic [7:0]      cfg_wdata = '0;
  logic            alt_board = 1'b0;
  logic [1:0]      mode_default = 2'd0;
  logic [4*NSLOT-1:0] pin_req = '0;
  logic [3:0]      irq_out;
  logic [1:0]      mode;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [1:0] exp_mode = 2'd0;
  logic [3:0] exp_irq  = 4'd0;

  always #5 clk = ~clk;

  irq_autoroute #(.NUM_SLOTS(NSLOT), .ADDR_W(AW)) u_irq_autoroute (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .alt_board(alt_board), .mode_default(mode_default),
    .pin_req(pin_req), .irq_out(irq_out), .mode(mode)
  );

  function automatic logic [1:0] ref_class(input int slot, input int v);
    int s;
    s = slot % 4;
    if (v == 27) return (s == 2) ? 2'd0 : 2'd1;
    if (v == s + 27 || v == s + 91) return 2'd1;
    return 2'd2;
  endfunction

  function automatic logic [3:0] ref_route(input logic [4*NSLOT-1:0] req,
                                           input logic [1:0] md, input logic alt);
    logic [3:0] r;
    r = '0;
    for (int s = 0; s < NSLOT; s++) begin
      for (int p = 0; p < 4; p++) begin
        if (req[4*s+p]) begin
          if (md == 2'd1) r[p] = 1'b1;
          else r[(s + p + (alt ? 3 : 2)) % 4] = 1'b1;
        end
      end
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One clock: update the model at the edge, compare at the falling edge.
  task automatic step(input string mtag);
    string rtag;
    @(posedge clk);
    if (rst) begin
      exp_irq  = 4'd0;
      exp_mode = (mode_default == 2'd3) ? 2'd0 : mode_default;
    end else begin
      exp_irq = ref_route(pin_req, exp_mode, alt_board);
      if (cfg_wr && !alt_board && cfg_addr[7:0] == 8'h3C && exp_mode == 2'd0)
        exp_mode = ref_class(int'(cfg_addr[15:11]), int'(cfg_wdata));
    end
    rtag = (exp_mode == 2'd1) ? "R6 route" : "R7 route";
    @(negedge clk);
    check(mtag, {2'b00, mode}, {2'b00, exp_mode});
    check(rtag, irq_out, exp_irq);
    cfg_wr = 1'b0;
  endtask

  task automatic do_reset(input logic [1:0] dflt);
    rst = 1'b1; mode_default = dflt;
    step("R1 reset mode");
    step("R1 reset mode");
    rst = 1'b0;
  endtask

  task automatic wr_line(input int slot, input int off, input int v, input string tag);
    cfg_wr = 1'b1;
    cfg_addr = AW'((slot << 11) | off);
    cfg_wdata = 8'(v);
    step(tag);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h1A2B3C);
    @(negedge clk);
    do_reset(2'd0);
    check("R1 irq zero after reset", irq_out, 4'd0);
    do_reset(2'd1); check("R1 default broken", {2'b0, mode}, 4'd1);
    do_reset(2'd2); check("R1 default force", {2'b0, mode}, 4'd2);
    do_reset(2'd3); check("R1 spare code", {2'b0, mode}, 4'd0);

    wr_line(2, 8'h3C, 27, "R5 slot2 v27 stays");
    wr_line(6, 8'h3D, 99, "R3 other offset");
    alt_board = 1'b1;
    wr_line(1, 8'h3C, 99, "R4 alt no detect");
    pin_req = 32'h0000_0011;
    step("R7 alt route"); step("R7 alt route");
    alt_board = 1'b0;
    step("R7 primary route");
    wr_line(6, 8'h3C, 29, "R5 slot6 v29 broken");
    pin_req = 32'h0000_0021;
    step("R6 legacy route"); step("R6 legacy route");
    wr_line(0, 8'h3C, 99, "R2 sticky broken");

    do_reset(2'd0);
    wr_line(1, 8'h3C, 92, "R5 shifted broken");
    do_reset(2'd0);
    wr_line(3, 8'h3C, 99, "R5 other value force");
    wr_line(0, 8'h3C, 27, "R2 sticky force");
    // R8: two sources on one line, release one, line stays high
    pin_req = 32'h0000_0010 | 32'h0000_0100; // slot1 INTA, slot2 INTA -> 3 and 0
    pin_req = 32'h0000_0002 | 32'h0000_0010; // slot0 INTB and slot1 INTA -> both 3
    step("R8 shared line"); step("R8 shared line");
    check("R8 line high", irq_out, 4'b1000);
    pin_req = 32'h0000_0010;
    step("R8 shared line"); step("R8 shared line");
    check("R8 stays high", irq_out, 4'b1000);
    pin_req = '0;
    step("R8 idle"); step("R8 idle");

    // R9: write during reset ignored
    rst = 1'b1; mode_default = 2'd0;
    cfg_wr = 1'b1; cfg_addr = 16'h083C; cfg_wdata = 8'd99;
    step("R9 write in reset");
    rst = 1'b0;
    step("R9 mode after reset");
    check("R9 still assume", {2'b0, mode}, 4'd0);

    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 40) == 0) begin
        do_reset(2'($urandom_range(0, 3)));
      end
      alt_board = ($urandom_range(0, 7) == 0);
      pin_req = $urandom() & $urandom();
      if ($urandom_range(0, 2) == 0) begin
        int v;
        case ($urandom_range(0, 3))
          0: v = 27 + int'($urandom_range(0, 3));
          1: v = 91 + int'($urandom_range(0, 3));
          2: v = 27;
          default: v = int'($urandom_range(0, 255));
        endcase
        wr_line(int'($urandom_range(0, 31)),
                ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 255)) : 8'h3C,
                v, "R5 random");
      end else begin
        step("R2 random hold");
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule